// File: doc/BRIEF.md
# SD Command Response Checker

This block follows the CMD line after the host has finished sending a command. It decides whether a card reply arrived in time, and checks the reply it receives. A one-cycle `issue` pulse is raised in the cycle that carries the command's end bit. With that pulse come the index of the command, the expected reply length, and two check enables. The block then samples `cmd_in` once per SD clock until one of two things happens: the reply is complete, or the wait window runs out.

The block reports on five one-cycle outputs: completion, timeout, CRC7 mismatch, bad end bit and index mismatch. The error outputs pulse in the same cycle as the completion pulse of the reply they belong to. Internally, a busy flag is high from an accepted issue until the reply or timeout has been handled. Completion marks the fall of that flag.

Top module: `sd_rsp_check`

## Requirements
- R1: When `rsp_len` is 0 (no reply expected) at an accepted issue, `cc` pulses in the first cycle after the issue cycle, and `cto` does not pulse.
- R2: When a reply is expected and `cmd_in` is sampled high in each of the `TIMEOUT_CYC` (64) cycles after the issue cycle, `cto` pulses exactly `TIMEOUT_CYC` cycles after the issue cycle, and `cc` does not pulse for that command.
- R3: A start bit (0) sampled in the last cycle of the window is accepted: there is no timeout and the reply is received normally.
- R4: `rsp_len` 1 selects a 48-bit reply and values 2 or 3 select a 136-bit reply. The first 0 on `cmd_in` is bit 0 of the reply. `cc` pulses in the first cycle after the last reply bit is sampled, so it comes N cycles after the start bit for an N-bit reply.
- R5: For 48-bit replies with `crc_chk_en` set at issue, `ccrc` pulses with `cc` when reply bits 40..46 (MSB first) differ from the CRC7 (x^7+x^3+1, zero seed) of bits 0..39. With the enable clear, `ccrc` stays low.
- R6: `ceb` pulses with `cc` when the last reply bit (bit 47 or bit 135) is sampled as 0.
- R7: For 48-bit replies with `idx_chk_en` set at issue, `cie` pulses with `cc` when reply bits 2..7 (MSB first) differ from `issue_idx`. With the enable clear, `cie` stays low.
- R8: For 136-bit replies, `ccrc` and `cie` never pulse, whatever the enables and the reply content. The end-bit check still applies.
- R9: An `issue` pulse that arrives while a previous command is still pending is ignored. No extra `cc` results, and the pending reply is checked against the first command.
- R10: `cc` and `cto` never pulse in the same cycle. Each error pulse occurs only together with `cc`.
- R11: While `rst_n` is low all outputs are low. A reset during a pending wait cancels it, so no timeout follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SD clock; `cmd_in` sampled on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_in | input | 1 | Sampled CMD line, idle high |
| issue | input | 1 | Pulse in the command end-bit cycle |
| issue_idx | input | IDX_W | Index of the command just sent |
| rsp_len | input | 2 | 0 none, 1 48-bit, 2/3 136-bit |
| crc_chk_en | input | 1 | Enable CRC7 check for this command |
| idx_chk_en | input | 1 | Enable index check for this command |
| cc | output | 1 | Command complete pulse |
| cto | output | 1 | Command timeout pulse |
| ccrc | output | 1 | Reply CRC7 error pulse |
| ceb | output | 1 | Reply end-bit error pulse |
| cie | output | 1 | Reply index error pulse |

## Verification
The bench builds the block with its default parameters: a 64-cycle window, 48- and 136-bit reply lengths and a 6-bit index. With these values both edges of the timeout window fit into a run of under a hundred cycles: a start bit in the 64th cycle and silence through it. Full 136-bit frames stay short enough to replay with corrupted index, CRC and end-bit fields. Cycle-exact timestamps on `cc` and `cto`, counted from the issue cycle, tie each pulse to the window length and the reply length.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2,
        RSP_LONGX = 2'd3
    } rsp_len_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2
    } rsp_st_e;
endpackage

// File: rtl/sd_rsp_crc7.sv
// Serial CRC accumulator, MSB-first feed, zero seed.
module sd_rsp_crc7 #(
    parameter int              W    = 7,
    parameter logic [W-1:0]    POLY = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        fb    = din ^ crc_q[W-1];
        crc_d = crc_q;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sd_rsp_wait_timer.sv
// Counts idle cycles while run is high; expired flags the last allowed one.
module sd_rsp_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (clr)                  cnt_d = '0;
        else if (run && !expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sd_rsp_check.sv
module sd_rsp_check
    import sd_rsp_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int SHORT_BITS  = 48,
    parameter int LONG_BITS   = 136,
    parameter int IDX_W       = 6,
    parameter int CRC_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_in,
    input  logic             issue,
    input  logic [IDX_W-1:0] issue_idx,
    input  logic [1:0]       rsp_len,
    input  logic             crc_chk_en,
    input  logic             idx_chk_en,
    output logic             cc,
    output logic             cto,
    output logic             ccrc,
    output logic             ceb,
    output logic             cie
);
    localparam int POS_W = $clog2(LONG_BITS);
    localparam logic [POS_W-1:0] P_IDX_LO = POS_W'(2);
    localparam logic [POS_W-1:0] P_IDX_HI = POS_W'(2 + IDX_W - 1);
    localparam logic [POS_W-1:0] P_CRC_LO = POS_W'(SHORT_BITS - 1 - CRC_W);
    localparam logic [POS_W-1:0] P_END_S  = POS_W'(SHORT_BITS - 1);
    localparam logic [POS_W-1:0] P_END_L  = POS_W'(LONG_BITS - 1);

    typedef struct packed {
        rsp_st_e          st;
        logic             is_long;
        logic             crc_en;
        logic             idx_en;
        logic [IDX_W-1:0] idx_exp;
        logic [IDX_W-1:0] idx_rx;
        logic [CRC_W-1:0] crc_rx;
        logic [POS_W-1:0] pos;
        logic             cc;
        logic             cto;
        logic             ccrc;
        logic             ceb;
        logic             cie;
    } chk_state_t;

    chk_state_t       s_d, s_q;
    logic             start_ok;
    logic             crc_feed;
    logic             tmr_run;
    logic             tmr_exp;
    logic             last_bit;
    logic [CRC_W-1:0] crc_calc;
    rsp_len_e         len_in;

    assign len_in   = rsp_len_e'(rsp_len);
    assign start_ok = (s_q.st == ST_IDLE) && issue;

    sd_rsp_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_ok),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    sd_rsp_crc7 #(.W(CRC_W), .POLY(CRC_W'(7'h09))) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .en    (crc_feed),
        .din   (cmd_in),
        .crc   (crc_calc)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cc   = 1'b0;
        s_d.cto  = 1'b0;
        s_d.ccrc = 1'b0;
        s_d.ceb  = 1'b0;
        s_d.cie  = 1'b0;
        crc_feed = 1'b0;
        tmr_run  = 1'b0;
        last_bit = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (issue) begin
                    s_d.idx_exp = issue_idx;
                    s_d.crc_en  = crc_chk_en;
                    s_d.idx_en  = idx_chk_en;
                    s_d.is_long = (len_in == RSP_LONG) || (len_in == RSP_LONGX);
                    if (len_in == RSP_NONE) s_d.cc = 1'b1;
                    else                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!cmd_in) begin
                    crc_feed = 1'b1;
                    s_d.st   = ST_RECV;
                    s_d.pos  = POS_W'(1);
                end else begin
                    tmr_run = 1'b1;
                    if (tmr_exp) begin
                        s_d.cto = 1'b1;
                        s_d.st  = ST_IDLE;
                    end
                end
            end
            ST_RECV: begin
                s_d.pos = s_q.pos + 1'b1;
                if (s_q.pos >= P_IDX_LO && s_q.pos <= P_IDX_HI)
                    s_d.idx_rx = {s_q.idx_rx[IDX_W-2:0], cmd_in};
                if (s_q.pos < P_CRC_LO)
                    crc_feed = 1'b1;
                else if (s_q.pos < P_END_S)
                    s_d.crc_rx = {s_q.crc_rx[CRC_W-2:0], cmd_in};
                last_bit = s_q.is_long ? (s_q.pos == P_END_L) : (s_q.pos == P_END_S);
                if (last_bit) begin
                    s_d.st  = ST_IDLE;
                    s_d.cc  = 1'b1;
                    s_d.ceb = !cmd_in;
                    if (!s_q.is_long) begin
                        s_d.ccrc = s_q.crc_en && (s_q.crc_rx != crc_calc);
                        s_d.cie  = s_q.idx_en && (s_q.idx_rx != s_q.idx_exp);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign cc   = s_q.cc;
    assign cto  = s_q.cto;
    assign ccrc = s_q.ccrc;
    assign ceb  = s_q.ceb;
    assign cie  = s_q.cie;
endmodule

// File: rtl/sd_rsp_check_sva.sv
module sd_rsp_check_sva (
    input logic clk,
    input logic rst_n,
    input logic cmd_in,
    input logic cc,
    input logic cto,
    input logic ccrc,
    input logic ceb,
    input logic cie
);
    // R10: completion and timeout are exclusive
    assert_cc_cto_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cc && cto));

    // R5: CRC error only alongside completion
    assert_crc_with_cc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ccrc |-> cc);

    // R6: end-bit error only alongside completion
    assert_eb_with_cc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ceb |-> cc);

    // R7: index error only alongside completion
    assert_idx_with_cc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cie |-> cc);

    // R2: a timeout follows a cycle in which the line was sampled high
    assert_cto_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cto |-> $past(cmd_in));

    // R6: an end-bit error follows a cycle in which the line was sampled low
    assert_eb_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ceb |-> !$past(cmd_in));
endmodule

bind sd_rsp_check sd_rsp_check_sva u_sd_rsp_check_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_in (cmd_in),
    .cc     (cc),
    .cto    (cto),
    .ccrc   (ccrc),
    .ceb    (ceb),
    .cie    (cie)
);

// File: tb/sd_rsp_check_bench.sv
module sd_rsp_check_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_in = 1'b1;
    logic       issue = 1'b0;
    logic [5:0] issue_idx = '0;
    logic [1:0] rsp_len = '0;
    logic       crc_chk_en = 1'b0;
    logic       idx_chk_en = 1'b0;
    logic       cc, cto, ccrc, ceb, cie;

    int n_chk = 0, n_bad = 0;
    int edge_n = 0;
    int n_cc, n_cto, n_ccrc, n_ceb, n_cie, t_cc, t_cto, t_issue;
    bit done = 0;

    always #4 clk = ~clk;

    sd_rsp_check u_sd_rsp_check (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .issue(issue),
        .issue_idx(issue_idx), .rsp_len(rsp_len), .crc_chk_en(crc_chk_en),
        .idx_chk_en(idx_chk_en), .cc(cc), .cto(cto), .ccrc(ccrc),
        .ceb(ceb), .cie(cie)
    );

    always @(posedge clk) begin
        #1;
        edge_n++;
        if (cc)   begin n_cc++;  t_cc  = edge_n; end
        if (cto)  begin n_cto++; t_cto = edge_n; end
        if (ccrc) n_ccrc++;
        if (ceb)  n_ceb++;
        if (cie)  n_cie++;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_cc = 0; n_cto = 0; n_ccrc = 0; n_ceb = 0; n_cie = 0;
        t_cc = -1; t_cto = -1;
    endtask

    function automatic logic [6:0] crc_of(logic [39:0] v);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // fields: len[25:24] idx_sent[23:18] idx_rsp[17:12] crc_en[11] idx_en[10]
    //         bad_crc[9] bad_end[8] gap[7:0]
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 6'd0,  6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0},   // R1
        {2'd1, 6'd17, 6'd17, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2},   // R4 clean
        {2'd1, 6'd17, 6'd17, 1'b1, 1'b0, 1'b1, 1'b0, 8'd5},   // R5 crc err
        {2'd1, 6'd8,  6'd8,  1'b0, 1'b1, 1'b1, 1'b0, 8'd0},   // R5 disabled
        {2'd1, 6'd3,  6'd41, 1'b0, 1'b1, 1'b0, 1'b0, 8'd7},   // R7 idx err
        {2'd1, 6'd3,  6'd41, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},   // R7 disabled
        {2'd1, 6'd55, 6'd55, 1'b1, 1'b1, 1'b0, 1'b1, 8'd4},   // R6 end bit
        {2'd1, 6'd9,  6'd9,  1'b1, 1'b1, 1'b0, 1'b0, 8'd63},  // R3 late start
        {2'd1, 6'd9,  6'd9,  1'b1, 1'b1, 1'b0, 1'b0, 8'd64},  // R2 timeout
        {2'd2, 6'd2,  6'd63, 1'b1, 1'b1, 1'b1, 1'b0, 8'd1},   // R8 skip checks
        {2'd3, 6'd2,  6'd2,  1'b1, 1'b1, 1'b0, 1'b1, 8'd3},   // R8 end bit
        {2'd0, 6'd63, 6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 8'd0}    // R1 again
    };

    task automatic send_bits(logic [135:0] fr, int nb);
        for (int i = nb - 1; i >= 0; i--) begin
            cmd_in = fr[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    function automatic logic [135:0] mk_frame(logic lng, logic [5:0] ir,
                                              logic bc, logic be, int seed);
        logic [135:0] f = '0;
        if (!lng) begin
            logic [39:0] h = {2'b00, ir, 32'hA5C3_0F00 ^ 32'(seed * 32'h9E37)};
            f[47:0] = {h, crc_of(h) ^ {6'd0, bc}, ~be};
        end else begin
            f = {2'b00, ir, {4{30'h2AC5_1B7F ^ 30'(seed)}}, 7'h35 ^ {6'd0, bc}, ~be};
        end
        return f;
    endfunction

    initial begin
        clr_mon();
        repeat (3) @(negedge clk);
        chk("R11 reset cc",  int'(cc),  0);
        chk("R11 reset cto", int'(cto), 0);
        chk("R11 reset err", int'(ccrc | ceb | cie), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] ln = VEC[v][25:24];
            logic [5:0] is = VEC[v][23:18];
            logic [5:0] ir = VEC[v][17:12];
            logic ce = VEC[v][11], ie = VEC[v][10];
            logic bc = VEC[v][9],  be = VEC[v][8];
            int g = int'(VEC[v][7:0]);
            logic lng = ln[1];
            int nb = lng ? 136 : 48;
            clr_mon();
            issue = 1'b1; issue_idx = is; rsp_len = ln;
            crc_chk_en = ce; idx_chk_en = ie;
            t_issue = edge_n + 1;
            @(negedge clk);
            issue = 1'b0;
            if (ln != 2'd0) begin
                for (int i = 0; i < g; i++) begin
                    cmd_in = 1'b1;
                    @(negedge clk);
                end
                if (g < 64) send_bits(mk_frame(lng, ir, bc, be, v), nb);
            end
            repeat (80) @(negedge clk);
            if (ln == 2'd0) begin
                chk("R1 cc count", n_cc, 1);
                chk("R1 cc delay", t_cc - t_issue, 0);
                chk("R1 no cto", n_cto, 0);
            end else if (g >= 64) begin
                chk("R2 cto count", n_cto, 1);
                chk("R2 cto delay", t_cto - t_issue, 64);
                chk("R2 no cc", n_cc, 0);
                chk("R10 no err", n_ccrc + n_ceb + n_cie, 0);
            end else begin
                chk(g == 63 ? "R3 cc count" : "R4 cc count", n_cc, 1);
                chk(g == 63 ? "R3 no cto" : "R4 no cto", n_cto, 0);
                chk("R4 cc delay", t_cc - t_issue, g + nb);
                chk(lng ? "R8 ccrc" : "R5 ccrc", n_ccrc, int'(!lng && ce && bc));
                chk(lng ? "R8 cie" : "R7 cie", n_cie, int'(!lng && ie && (is != ir)));
                chk(lng ? "R8 ceb" : "R6 ceb", n_ceb, int'(be));
            end
        end

        // R9: second issue during pending wait is ignored
        clr_mon();
        issue = 1'b1; issue_idx = 6'd12; rsp_len = 2'd1;
        crc_chk_en = 1'b1; idx_chk_en = 1'b1;
        t_issue = edge_n + 1;
        @(negedge clk);
        issue = 1'b0;
        repeat (3) @(negedge clk);
        issue = 1'b1; issue_idx = 6'd40; rsp_len = 2'd0;
        @(negedge clk);
        issue = 1'b0;
        repeat (4) @(negedge clk);
        send_bits(mk_frame(1'b0, 6'd12, 1'b0, 1'b0, 99), 48);
        repeat (80) @(negedge clk);
        chk("R9 single cc", n_cc, 1);
        chk("R9 cc delay", t_cc - t_issue, 8 + 48);
        chk("R9 first index kept", n_cie, 0);
        chk("R9 no cto", n_cto, 0);

        // R11: reset cancels a pending wait
        clr_mon();
        issue = 1'b1; rsp_len = 2'd1;
        @(negedge clk);
        issue = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 outputs low in reset", int'(cc | cto | ccrc | ceb | cie), 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk("R11 no cto after reset", n_cto, 0);
        chk("R11 no cc after reset", n_cc, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule